// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns a 16-bit word, delivered one bit at a time, into a framed Manchester II line signal on two complementary outputs. Every frame takes twenty bit times. It opens with a three-bit-time sync whose polarity marks the word as a command or as data. Sixteen Manchester-coded data bits follow, most significant first, and an odd parity bit closes the frame. The design runs from one system clock. The half-bit timing comes from a one-cycle send strobe at twice the bit rate. That strobe is either supplied from outside or produced by an on-block divide-by-six prescaler driven from a faster encoder clock strobe.

The host raises the enable. While the request output is high, the host supplies one serial bit per bit period, and each bit is taken on the rising edge of the bit-rate shift clock that the block drives out. If the enable is still high when the parity bit goes out, the next frame follows with no gap. An active-low inhibit holds both line outputs high and leaves the sequencing untouched. A master reset pulse aborts a frame in progress at the next send strobe.

Top module: `manchester_word_encoder`

## Requirements
- R1: The shift clock output toggles on every send strobe. It is high in the first half of each bit period and low in the second half, and system reset leaves it high.
- R2: A frame begins only when the enable is high at a falling shift-clock edge, and only while the block is idle or in the parity bit period. The frame starts at the following rising edge and lasts exactly 20 bit periods, numbered 0 to 19.
- R3: Sync select is sampled at the rising edge that opens bit period 0. A high selects a command sync: three half-bits high, then three half-bits low, on the bipolar-one output. A low selects a data sync, which is the inverse.
- R4: The send-data request is high for exactly 16 bit periods, namely periods 2 to 17 of each frame, and low at all other times.
- R5: Serial data is sampled at the rising shift-clock edge that ends each request period, word bit 15 first. Each sampled bit is sent in bit periods 3 to 18. A one is sent as high then low on bipolar-one, and a zero as low then high.
- R6: Bit period 19 carries a parity bit that makes the number of ones over the 16 data bits plus parity odd. It is Manchester coded like a data bit.
- R7: With the enable held high, frames follow one another with no idle half-bit between them. The enable has no effect at any time other than the falling edges named in R2, so dropping it in the middle of a frame does not cut the frame short.
- R8: While a frame is on the line and not inhibited, bipolar-zero is the complement of bipolar-one. When idle, both outputs are high.
- R9: A low on the inhibit input forces both line outputs high. It does not change the shift clock, the request, or the timing and content of later half-bits.
- R10: A master reset pulse is held until the next send strobe, or acts on a strobe that arrives while it is high. At that strobe the frame is dropped, both outputs go idle, the shift clock returns high, and a new frame can start two strobes later.
- R11: The prescale output is a one-cycle pulse on every sixth encoder clock strobe. When the prescaler option is selected, these pulses serve as the send strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| encClkEn | input | 1 | Encoder clock strobe feeding the prescaler |
| sendClkEn | input | 1 | Send strobe at twice the bit rate (used when the prescaler is not selected) |
| encEnable | input | 1 | Request to encode a frame |
| syncSelect | input | 1 | 1 = command sync, 0 = data sync |
| serialData | input | 1 | Serial data bit, MSB first |
| masterReset | input | 1 | Abort pulse, high active |
| outInhibitN | input | 1 | Low forces both line outputs high |
| shiftClk | output | 1 | Bit-rate shift clock level |
| sendData | output | 1 | Request for serial data |
| bipolarOne | output | 1 | True line output |
| bipolarZero | output | 1 | Complement line output |
| prescaleOut | output | 1 | Divide-by-six pulse output |

## Verification
The bench streams six words back to back. The words include all zeros, all ones, single-ended and alternating patterns, and both sync kinds, and the bench compares every half-bit with a frame it builds arithmetically. A wrong sync polarity, a shifted data window, a bit-order swap or even parity would each disagree at a known half-bit. The bench drops the enable in the middle of a frame, which catches a design that aborts early or leaves a gap between frames. It also raises the enable only at a rising edge, which catches a design that starts on the wrong edge. It inhibits the line for several half-bits and then confirms that the following half-bits are still in step. Master reset is applied both as a pulse between strobes and as a level across a strobe. A design that ignores the latched form, or that does not return the shift clock high, would misalign the next frame.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  typedef enum logic [1:0] {
    PART_SYNC   = 2'd0,
    PART_DATA   = 2'd1,
    PART_PARITY = 2'd2
  } framePart_e;

  typedef struct packed {
    logic       clear;
    logic       bitStart;
    logic       bitMid;
    framePart_e part;
    logic [1:0] syncSlot;
  } encStrobe_t;

endpackage

// File: rtl/mwe_prescaler.sv
module mwe_prescaler #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic encClkEn,
  output logic tickOut
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (encClkEn) begin
      divCnt <= (divCnt == LAST) ? '0 : divCnt + CW'(1);
    end
  end

  assign tickOut = encClkEn && (divCnt == LAST);

  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tickOut |=> !tickOut);

endmodule

// File: rtl/mwe_control.sv
module mwe_control
  import mwe_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sendTick,
  input  logic       encEnable,
  input  logic       masterReset,
  output encStrobe_t strobe,
  output logic       shiftClk,
  output logic       sendData,
  output logic       active
);
  localparam int FRAME_SLOTS = DATA_BITS + 4;
  localparam int SLOT_W = $clog2(FRAME_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] REQ_FIRST = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] REQ_LAST = SLOT_W'(DATA_BITS + 1);
  localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] DATA_LAST = SLOT_W'(DATA_BITS + 2);

  logic              secondHalf;
  logic              running;
  logic              armed;
  logic              pendRst;
  logic [SLOT_W-1:0] slot;

  logic              clearNow, riseNow, fallNow, atLast, nextRun;
  logic [SLOT_W-1:0] nextSlot, selSlot;

  always_comb begin
    clearNow = sendTick && (masterReset || pendRst);
    riseNow  = sendTick && !clearNow && secondHalf;
    fallNow  = sendTick && !clearNow && !secondHalf;
    atLast   = running && (slot == LAST_SLOT);
    nextSlot = armed ? '0 : slot + SLOT_W'(1);
    nextRun  = armed || (running && !atLast);
    selSlot  = riseNow ? nextSlot : slot;

    strobe.clear    = clearNow;
    strobe.bitStart = riseNow && nextRun;
    strobe.bitMid   = fallNow && running;
    strobe.syncSlot = selSlot[1:0];
    if (selSlot < DATA_FIRST)       strobe.part = PART_SYNC;
    else if (selSlot <= DATA_LAST)  strobe.part = PART_DATA;
    else                            strobe.part = PART_PARITY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secondHalf <= 1'b0;
      running    <= 1'b0;
      armed      <= 1'b0;
      pendRst    <= 1'b0;
      slot       <= '0;
    end else begin
      if (masterReset && !sendTick) pendRst <= 1'b1;
      if (clearNow) begin
        secondHalf <= 1'b0;
        running    <= 1'b0;
        armed      <= 1'b0;
        pendRst    <= 1'b0;
        slot       <= '0;
      end else if (sendTick) begin
        secondHalf <= ~secondHalf;
        if (!secondHalf) begin
          if (encEnable && (!running || atLast)) armed <= 1'b1;
        end else begin
          running <= nextRun;
          slot    <= nextRun ? nextSlot : '0;
          armed   <= 1'b0;
        end
      end
    end
  end

  assign shiftClk = ~secondHalf;
  assign sendData = running && (slot >= REQ_FIRST) && (slot <= REQ_LAST);
  assign active   = running;

  // Slot counter stays within one frame
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (slot <= LAST_SLOT));

  // Arming happens only while idle or in the parity period
  assert_arm_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (!running || slot == LAST_SLOT));

  // Each accepted send strobe flips the shift clock
  assert_shift_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sendTick && !masterReset && !pendRst) |=> (shiftClk != $past(shiftClk)));

  // A clearing strobe leaves the block idle with the shift clock high
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sendTick && (masterReset || pendRst)) |=> (!running && shiftClk));

  // Request only during a running frame
  assert_request_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sendData |-> running);

endmodule

// File: rtl/mwe_datapath.sv
module mwe_datapath
  import mwe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  encStrobe_t strobe,
  input  logic       syncSelect,
  input  logic       serialData,
  output logic       lineBit
);
  logic cmdSync;
  logic curBit;
  logic parAcc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineBit <= 1'b1;
      cmdSync <= 1'b0;
      curBit  <= 1'b0;
      parAcc  <= 1'b0;
    end else if (strobe.clear) begin
      lineBit <= 1'b1;
      parAcc  <= 1'b0;
    end else if (strobe.bitStart) begin
      case (strobe.part)
        PART_SYNC: begin
          case (strobe.syncSlot)
            2'd0: begin
              cmdSync <= syncSelect;
              lineBit <= syncSelect;
              parAcc  <= 1'b0;
            end
            2'd1:    lineBit <= cmdSync;
            default: lineBit <= ~cmdSync;
          endcase
        end
        PART_DATA: begin
          lineBit <= serialData;
          curBit  <= serialData;
          parAcc  <= parAcc ^ serialData;
        end
        default: begin
          lineBit <= ~parAcc;
          curBit  <= ~parAcc;
        end
      endcase
    end else if (strobe.bitMid) begin
      if (strobe.part == PART_SYNC) begin
        lineBit <= (strobe.syncSlot == 2'd0) ? cmdSync : ~cmdSync;
      end else begin
        lineBit <= ~curBit;
      end
    end
  end

  // Every coded bit changes level at mid-period
  assert_mid_transition_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.bitMid && !strobe.clear && strobe.part != PART_SYNC) |=> (lineBit != $past(lineBit)));

endmodule

// File: rtl/manchester_word_encoder.sv
module manchester_word_encoder
  import mwe_pkg::*;
#(
  parameter int DATA_BITS     = 16,
  parameter int PRESCALE_DIV  = 6,
  parameter bit USE_PRESCALER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic encClkEn,
  input  logic sendClkEn,
  input  logic encEnable,
  input  logic syncSelect,
  input  logic serialData,
  input  logic masterReset,
  input  logic outInhibitN,
  output logic shiftClk,
  output logic sendData,
  output logic bipolarOne,
  output logic bipolarZero,
  output logic prescaleOut
);
  encStrobe_t strobe;
  logic       sendTick;
  logic       active;
  logic       lineBit;
  logic       driveLine;

  mwe_prescaler #(.DIV(PRESCALE_DIV)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .encClkEn (encClkEn),
    .tickOut  (prescaleOut)
  );

  generate
    if (USE_PRESCALER) begin : g_internalTick
      assign sendTick = prescaleOut;
    end else begin : g_externalTick
      assign sendTick = sendClkEn;
    end
  endgenerate

  mwe_control #(.DATA_BITS(DATA_BITS)) u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .sendTick    (sendTick),
    .encEnable   (encEnable),
    .masterReset (masterReset),
    .strobe      (strobe),
    .shiftClk    (shiftClk),
    .sendData    (sendData),
    .active      (active)
  );

  mwe_datapath u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .syncSelect (syncSelect),
    .serialData (serialData),
    .lineBit    (lineBit)
  );

  assign driveLine   = active && outInhibitN;
  assign bipolarOne  = driveLine ? lineBit : 1'b1;
  assign bipolarZero = driveLine ? ~lineBit : 1'b1;

  assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && outInhibitN) |-> (bipolarOne != bipolarZero));

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (bipolarOne && bipolarZero));

  assert_inhibit_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !outInhibitN |-> (bipolarOne && bipolarZero));

endmodule

// File: tb/manchester_word_encoder_tb.sv
module manchester_word_encoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic encClkEn = 1'b1;
  logic sendClkEn = 1'b0;
  logic encEnable = 1'b0;
  logic syncSelect = 1'b0;
  logic serialData = 1'b0;
  logic masterReset = 1'b0;
  logic outInhibitN = 1'b1;
  logic shiftClk, sendData, bipolarOne, bipolarZero, prescaleOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [15:0] wordArr [0:7];
  logic        syncArr [0:7];

  always #10 clk = ~clk;

  manchester_word_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .encClkEn(encClkEn), .sendClkEn(sendClkEn),
    .encEnable(encEnable), .syncSelect(syncSelect), .serialData(serialData),
    .masterReset(masterReset), .outInhibitN(outInhibitN), .shiftClk(shiftClk),
    .sendData(sendData), .bipolarOne(bipolarOne), .bipolarZero(bipolarZero),
    .prescaleOut(prescaleOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick();
    @(negedge clk) sendClkEn = 1'b1;
    @(negedge clk) sendClkEn = 1'b0;
  endtask

  function automatic logic frameHalf(input logic [15:0] w, input logic cmd, input int hl);
    int sl = hl / 2;
    logic sec = hl[0];
    logic b;
    if (sl < 3) return cmd ? (hl < 3) : (hl >= 3);
    if (sl <= 18) begin
      b = w[15 - (sl - 3)];
      return sec ? ~b : b;
    end
    b = ~^w;
    return sec ? ~b : b;
  endfunction

  task automatic checkIdle(input string req, input logic expShift);
    check({bipolarOne, bipolarZero} == 2'b11, req, {bipolarOne, bipolarZero}, 3);
    check(sendData == 1'b0, req, sendData, 0);
    check(shiftClk == expShift, "R1", shiftClk, expShift);
  endtask

  // Starts with the shift clock high; ends with it high again.
  task automatic streamFrames(input int n, input int inhLo, input int inhHi);
    int total = 40 * n;
    encEnable = 1'b1;
    syncSelect = syncArr[0];
    serialData = 1'b0;
    outInhibitN = 1'b1;
    for (int p = 1; p <= total + 1; p++) begin
      int h, f, hl, sl, nh;
      logic expLine;
      string tag;
      doTick();
      h = p - 2;
      if (h >= 0) begin
        f = h / 40; hl = h % 40; sl = hl / 2;
        expLine = frameHalf(wordArr[f], syncArr[f], hl);
        if (!outInhibitN) begin
          check({bipolarOne, bipolarZero} == 2'b11, "R9", {bipolarOne, bipolarZero}, 3);
        end else begin
          tag = (sl < 3) ? "R3" : ((sl <= 18) ? "R5" : "R6");
          check(bipolarOne == expLine, tag, bipolarOne, expLine);
          check(bipolarZero == ~expLine, "R8", bipolarZero, ~expLine);
        end
        check(sendData == (sl >= 2 && sl <= 17), "R4", sendData, (sl >= 2 && sl <= 17));
        check(shiftClk == (hl[0] == 1'b0), "R1", shiftClk, (hl[0] == 1'b0));
      end else begin
        sl = -1; f = 0;
      end
      nh = h + 1;
      syncSelect = syncArr[(nh / 40) < n ? nh / 40 : n - 1];
      serialData = (sl >= 2 && sl <= 17) ? wordArr[f][15 - (sl - 2)] : ~serialData;
      // R7: enable dropped mid-frame is ignored; dropped before the last parity to stop
      encEnable = !((f == n - 1) && sl >= 16) && !(sl >= 5 && sl <= 9);
      outInhibitN = !(nh >= inhLo && nh <= inhHi);
    end
    outInhibitN = 1'b1;
    encEnable = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      doTick();
      checkIdle("R7", i[0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R8", 1'b1);

    // R11: prescaler pulse rate
    begin
      int pulses = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (prescaleOut) pulses++;
      end
      check(pulses == 10, "R11", pulses, 10);
    end

    // R2: enable high only at a rising edge does not start a frame
    encEnable = 1'b0; doTick(); checkIdle("R2", 1'b0);
    encEnable = 1'b1; doTick(); checkIdle("R2", 1'b1);
    encEnable = 1'b0; doTick(); checkIdle("R2", 1'b0);
    doTick(); checkIdle("R2", 1'b1);

    // R2, R7: six back-to-back frames with an inhibit window (R9)
    wordArr[0] = 16'h0000; syncArr[0] = 1'b1;
    wordArr[1] = 16'hFFFF; syncArr[1] = 1'b0;
    wordArr[2] = 16'hA5C3; syncArr[2] = 1'b0;
    wordArr[3] = 16'h8001; syncArr[3] = 1'b1;
    wordArr[4] = 16'h7FFE; syncArr[4] = 1'b1;
    wordArr[5] = 16'h1234; syncArr[5] = 1'b0;
    streamFrames(6, 50, 57);

    // R10: master reset pulse between strobes, then a clean frame
    encEnable = 1'b1; syncSelect = 1'b1;
    for (int i = 0; i < 13; i++) doTick();
    @(negedge clk) masterReset = 1'b1;
    @(negedge clk) masterReset = 1'b0;
    encEnable = 1'b0;
    doTick();
    checkIdle("R10", 1'b1);
    wordArr[0] = 16'h5A5A; syncArr[0] = 1'b0;
    streamFrames(1, -10, -10);

    // R10: master reset held across a strobe while data is requested
    encEnable = 1'b1; syncSelect = 1'b0;
    for (int i = 0; i < 30; i++) doTick();
    check(sendData == 1'b1, "R4", sendData, 1);
    encEnable = 1'b0;
    @(negedge clk) begin masterReset = 1'b1; sendClkEn = 1'b1; end
    @(negedge clk) begin masterReset = 1'b0; sendClkEn = 1'b0; end
    checkIdle("R10", 1'b1);
    wordArr[0] = 16'hC001; syncArr[0] = 1'b1;
    streamFrames(1, -10, -10);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule